// File: doc/BRIEF.md
# Zonal Coefficient Truncation and Zero-Fill Gate

This block sits between an 8x8 block transform and a word-wide SRAM. On the store side it follows the transform's output, one 36-bit word per cycle. Each word holds three 12-bit coefficients, one for each colour channel. Words arrive in raster order inside each 8x8 tile: row by row, left to right. A word goes to memory only when its position lies inside a square low-frequency zone, whose side is set by a 4-bit compression level. Kept words are packed at consecutive addresses. All other words are dropped.

On the load side the block walks the same tile geometry from a start address. It issues SRAM reads only for the positions in the zone and merges the returned words into a full 64-entry stream per tile. Every position outside the zone is filled with zero. The SRAM returns data two cycles after the address is issued, and the block lines up its zero insertion with that latency.

Each side latches its own level, tile count and base address when a frame starts, and finishes by itself after the programmed number of tiles.

Top module: `zonal_coef_gate`

## Requirements
- R1: Within a store frame with effective zone side N, the word at tile position (row r, column c) is written (mw_en_o high) exactly when r < N and c < N, with mw_data_o equal to xf_coef_i in the same cycle.
- R2: Written words go to consecutive addresses starting at wr_base_i, with no gaps across positions or tiles.
- R3: The effective zone side is 1 for level 0, equal to the level for 1 to 7, and 8 (all 64 positions) for level 8 or more.
- R4: The level, tile count and base are sampled at frame start; changing level_i during a frame has no effect on which positions are kept.
- R5: A store cycle with xf_ready_i low neither writes nor advances the tile position.
- R6: xf_rst_o is high when idle and low during a store frame. After the last position of the programmed tile count (0 counts as 1), the store frame ends: wr_busy_o falls, xf_rst_o rises, and further ready words are not written.
- R7: During a load frame one position is visited per cycle. mr_en_o is high exactly for positions inside the zone, and the addresses run consecutively from rd_base_i.
- R8: Exactly two cycles after a position is visited, co_valid_o is high. co_data_o then carries the SRAM word for a kept position and zero for a discarded one, including when the memory bus holds non-zero data.
- R9: A load frame yields 64 words per programmed tile (0 counts as 1). After that, co_valid_o and rd_busy_o fall.
- R10: Out of reset both sides are idle: no write, no read, no output valid, and xf_rst_o high.
- R11: A start request on either side is ignored while that side's frame is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| level_i | input | 4 | Compression level, sampled at frame start |
| tiles_i | input | 16 | Tiles per frame, sampled at frame start |
| wr_start_i | input | 1 | Store frame request |
| wr_base_i | input | 19 | First store address |
| xf_ready_i | input | 1 | Transform output word valid |
| xf_coef_i | input | 36 | Transform output word (3 x 12 bits) |
| xf_rst_o | output | 1 | Hold-in-reset toward the transform |
| wr_busy_o | output | 1 | Store frame in progress |
| mw_en_o | output | 1 | SRAM write strobe |
| mw_addr_o | output | 19 | SRAM write address |
| mw_data_o | output | 36 | SRAM write data |
| rd_start_i | input | 1 | Load frame request |
| rd_base_i | input | 19 | First load address |
| mr_en_o | output | 1 | SRAM read strobe |
| mr_addr_o | output | 19 | SRAM read address |
| mr_data_i | input | 36 | SRAM read data, two cycles after address |
| co_valid_o | output | 1 | Rebuilt coefficient valid |
| co_data_o | output | 36 | Rebuilt coefficient word |
| rd_busy_o | output | 1 | Load frame in progress, including drain |

## Verification
A wrong row or column count shows up in the first tile as a write or read strobe at a position outside the expected zone. A wrong address pointer shows on the very next kept word as a skipped or repeated address. A tile counter or end-of-frame fault shows only at the frame's last position, as a late or early drop of the busy flag and the transform reset. A misaligned read pipeline corrupts the rebuilt stream two cycles after the first visit: zeros appear where memory data belongs, or stale bus data where zeros belong. For that reason the memory model drives garbage on cycles without a read.

// File: rtl/zcg_pkg.sv
package zcg_pkg;
  localparam int TILE_SIDE = 8;
  localparam int POS_W     = $clog2(TILE_SIDE);

  // Zone side from a raw level: 0 -> 1, above TILE_SIDE -> TILE_SIDE.
  function automatic logic [3:0] zone_side(input logic [3:0] lvl);
    if (lvl == 4'd0)                 return 4'd1;
    else if (lvl >= 4'(TILE_SIDE))   return 4'(TILE_SIDE);
    else                             return lvl;
  endfunction
endpackage

// File: rtl/zcg_tile_walk.sv
module zcg_tile_walk
  import zcg_pkg::*;
#(
  parameter int TILE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              adv_i,
  input  logic [TILE_W-1:0] tiles_i,
  output logic [POS_W-1:0]  row_o,
  output logic [POS_W-1:0]  col_o,
  output logic              last_o
);
  localparam logic [POS_W-1:0] EDGE = POS_W'(TILE_SIDE - 1);

  logic [POS_W-1:0]  row_q, row_d, col_q, col_d;
  logic [TILE_W-1:0] tile_q, tile_d;
  logic              tile_end;

  assign tile_end = (row_q == EDGE) && (col_q == EDGE);
  assign last_o   = tile_end && (tile_q == tiles_i - TILE_W'(1));
  assign row_o    = row_q;
  assign col_o    = col_q;

  always_comb begin
    row_d  = row_q;
    col_d  = col_q;
    tile_d = tile_q;
    if (clr_i) begin
      row_d  = '0;
      col_d  = '0;
      tile_d = '0;
    end else if (adv_i) begin
      col_d = col_q + POS_W'(1);
      if (col_q == EDGE) row_d = row_q + POS_W'(1);
      if (tile_end)      tile_d = tile_q + TILE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q  <= '0;
      col_q  <= '0;
      tile_q <= '0;
    end else if (clr_i || adv_i) begin
      row_q  <= row_d;
      col_q  <= col_d;
      tile_q <= tile_d;
    end
  end
endmodule

// File: rtl/zcg_store.sv
module zcg_store
  import zcg_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int WORD_W = 36,
  parameter int TILE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        level_i,
  input  logic [TILE_W-1:0] tiles_i,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              ready_i,
  input  logic [WORD_W-1:0] coef_i,
  output logic              busy_o,
  output logic              xf_rst_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [WORD_W-1:0] data_o
);
  logic              busy_q, busy_d;
  logic [3:0]        side_q, side_d;
  logic [TILE_W-1:0] tiles_q, tiles_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic [POS_W-1:0]  row, col;
  logic              last, go, adv, keep;

  assign go   = start_i && !busy_q;
  assign adv  = busy_q && ready_i;
  assign keep = ({1'b0, row} < side_q) && ({1'b0, col} < side_q);

  zcg_tile_walk #(.TILE_W(TILE_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .clr_i(go), .adv_i(adv),
    .tiles_i(tiles_q), .row_o(row), .col_o(col), .last_o(last)
  );

  always_comb begin
    busy_d  = busy_q;
    side_d  = side_q;
    tiles_d = tiles_q;
    ptr_d   = ptr_q;
    if (go) begin
      busy_d  = 1'b1;
      side_d  = zone_side(level_i);
      tiles_d = (tiles_i == '0) ? TILE_W'(1) : tiles_i;
      ptr_d   = base_i;
    end else if (adv) begin
      if (keep) ptr_d = ptr_q + ADDR_W'(1);
      if (last) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      side_q  <= 4'd1;
      tiles_q <= TILE_W'(1);
      ptr_q   <= '0;
    end else if (go || adv) begin
      busy_q  <= busy_d;
      side_q  <= side_d;
      tiles_q <= tiles_d;
      ptr_q   <= ptr_d;
    end
  end

  assign busy_o   = busy_q;
  assign xf_rst_o = !busy_q;
  assign we_o     = adv && keep;
  assign addr_o   = ptr_q;
  assign data_o   = coef_i;
endmodule

// File: rtl/zcg_load.sv
module zcg_load
  import zcg_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int WORD_W = 36,
  parameter int TILE_W = 16,
  parameter int RD_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        level_i,
  input  logic [TILE_W-1:0] tiles_i,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic              re_o,
  output logic [ADDR_W-1:0] addr_o,
  input  logic [WORD_W-1:0] rdata_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] data_o,
  output logic              busy_o
);
  logic              act_q, act_d;
  logic [3:0]        side_q, side_d;
  logic [TILE_W-1:0] tiles_q, tiles_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic [POS_W-1:0]  row, col;
  logic              last, go, keep;
  logic [RD_LAT-1:0] vld_q, vld_d, kp_q, kp_d;

  assign busy_o = act_q || (|vld_q);
  assign go     = start_i && !busy_o;
  assign keep   = ({1'b0, row} < side_q) && ({1'b0, col} < side_q);

  zcg_tile_walk #(.TILE_W(TILE_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .clr_i(go), .adv_i(act_q),
    .tiles_i(tiles_q), .row_o(row), .col_o(col), .last_o(last)
  );

  always_comb begin
    act_d   = act_q;
    side_d  = side_q;
    tiles_d = tiles_q;
    ptr_d   = ptr_q;
    if (go) begin
      act_d   = 1'b1;
      side_d  = zone_side(level_i);
      tiles_d = (tiles_i == '0) ? TILE_W'(1) : tiles_i;
      ptr_d   = base_i;
    end else if (act_q) begin
      if (keep) ptr_d = ptr_q + ADDR_W'(1);
      if (last) act_d = 1'b0;
    end
  end

  // Delay line matching the memory read latency.
  generate
    if (RD_LAT == 1) begin : g_lat1
      always_comb begin
        vld_d = act_q;
        kp_d  = act_q && keep;
      end
    end else begin : g_latn
      always_comb begin
        vld_d = {vld_q[RD_LAT-2:0], act_q};
        kp_d  = {kp_q[RD_LAT-2:0], act_q && keep};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      side_q  <= 4'd1;
      tiles_q <= TILE_W'(1);
      ptr_q   <= '0;
    end else if (go || act_q) begin
      act_q   <= act_d;
      side_q  <= side_d;
      tiles_q <= tiles_d;
      ptr_q   <= ptr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      kp_q  <= '0;
    end else begin
      vld_q <= vld_d;
      kp_q  <= kp_d;
    end
  end

  assign re_o    = act_q && keep;
  assign addr_o  = ptr_q;
  assign valid_o = vld_q[RD_LAT-1];
  assign data_o  = kp_q[RD_LAT-1] ? rdata_i : '0;
endmodule

// File: rtl/zonal_coef_gate.sv
module zonal_coef_gate #(
  parameter int ADDR_W = 19,
  parameter int COEF_W = 12,
  parameter int LANES  = 3,
  parameter int TILE_W = 16,
  parameter int RD_LAT = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [3:0]              level_i,
  input  logic [TILE_W-1:0]       tiles_i,
  input  logic                    wr_start_i,
  input  logic [ADDR_W-1:0]       wr_base_i,
  input  logic                    xf_ready_i,
  input  logic [COEF_W*LANES-1:0] xf_coef_i,
  output logic                    xf_rst_o,
  output logic                    wr_busy_o,
  output logic                    mw_en_o,
  output logic [ADDR_W-1:0]       mw_addr_o,
  output logic [COEF_W*LANES-1:0] mw_data_o,
  input  logic                    rd_start_i,
  input  logic [ADDR_W-1:0]       rd_base_i,
  output logic                    mr_en_o,
  output logic [ADDR_W-1:0]       mr_addr_o,
  input  logic [COEF_W*LANES-1:0] mr_data_i,
  output logic                    co_valid_o,
  output logic [COEF_W*LANES-1:0] co_data_o,
  output logic                    rd_busy_o
);
  localparam int WORD_W = COEF_W * LANES;

  zcg_store #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .TILE_W(TILE_W)) u_store (
    .clk(clk), .rst_n(rst_n), .level_i(level_i), .tiles_i(tiles_i),
    .start_i(wr_start_i), .base_i(wr_base_i), .ready_i(xf_ready_i),
    .coef_i(xf_coef_i), .busy_o(wr_busy_o), .xf_rst_o(xf_rst_o),
    .we_o(mw_en_o), .addr_o(mw_addr_o), .data_o(mw_data_o)
  );

  zcg_load #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .TILE_W(TILE_W),
             .RD_LAT(RD_LAT)) u_load (
    .clk(clk), .rst_n(rst_n), .level_i(level_i), .tiles_i(tiles_i),
    .start_i(rd_start_i), .base_i(rd_base_i), .re_o(mr_en_o),
    .addr_o(mr_addr_o), .rdata_i(mr_data_i), .valid_o(co_valid_o),
    .data_o(co_data_o), .busy_o(rd_busy_o)
  );
endmodule

// File: rtl/zcg_checker.sv
module zcg_checker #(
  parameter int ADDR_W = 19,
  parameter int WORD_W = 36
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_start_i,
  input logic [ADDR_W-1:0] wr_base_i,
  input logic              xf_ready_i,
  input logic              xf_rst_o,
  input logic              wr_busy_o,
  input logic              mw_en_o,
  input logic [ADDR_W-1:0] mw_addr_o,
  input logic              rd_start_i,
  input logic [ADDR_W-1:0] rd_base_i,
  input logic              mr_en_o,
  input logic [ADDR_W-1:0] mr_addr_o,
  input logic              co_valid_o,
  input logic [WORD_W-1:0] co_data_o,
  input logic              rd_busy_o
);
  logic [ADDR_W-1:0] wr_exp_q, rd_exp_q;
  logic              en_d1_q, en_d2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_exp_q <= '0;
      rd_exp_q <= '0;
      en_d1_q  <= 1'b0;
      en_d2_q  <= 1'b0;
    end else begin
      if (wr_start_i && !wr_busy_o) wr_exp_q <= wr_base_i;
      else if (mw_en_o)             wr_exp_q <= mw_addr_o + ADDR_W'(1);
      if (rd_start_i && !rd_busy_o) rd_exp_q <= rd_base_i;
      else if (mr_en_o)             rd_exp_q <= mr_addr_o + ADDR_W'(1);
      en_d1_q <= mr_en_o;
      en_d2_q <= en_d1_q;
    end
  end

  p_wr_packed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mw_en_o |-> mw_addr_o == wr_exp_q);
  p_write_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mw_en_o |-> xf_ready_i);
  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    xf_rst_o |-> !mw_en_o);
  p_rd_packed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mr_en_o |-> mr_addr_o == rd_exp_q);
  p_zero_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (co_valid_o && !en_d2_q) |-> co_data_o == '0);
  p_rd_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_busy_o |-> (!mr_en_o && !co_valid_o));
endmodule

bind zonal_coef_gate zcg_checker #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_start_i(wr_start_i), .wr_base_i(wr_base_i),
  .xf_ready_i(xf_ready_i), .xf_rst_o(xf_rst_o), .wr_busy_o(wr_busy_o),
  .mw_en_o(mw_en_o), .mw_addr_o(mw_addr_o), .rd_start_i(rd_start_i),
  .rd_base_i(rd_base_i), .mr_en_o(mr_en_o), .mr_addr_o(mr_addr_o),
  .co_valid_o(co_valid_o), .co_data_o(co_data_o), .rd_busy_o(rd_busy_o)
);

// File: tb/zonal_coef_gate_test.sv
module zonal_coef_gate_test;
  logic        clk, rst_n;
  logic [3:0]  level_i;
  logic [15:0] tiles_i;
  logic        wr_start_i, xf_ready_i, rd_start_i;
  logic [18:0] wr_base_i, rd_base_i;
  logic [35:0] xf_coef_i, mr_data_i;
  logic        xf_rst_o, wr_busy_o, mw_en_o, mr_en_o, co_valid_o, rd_busy_o;
  logic [18:0] mw_addr_o, mr_addr_o;
  logic [35:0] mw_data_o, co_data_o;

  int total = 0;
  int bad   = 0;
  logic [35:0] mem [0:1023];
  logic [35:0] rd_d1, rd_d2;

  zonal_coef_gate uut (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // SRAM model: read data two cycles after address; garbage when idle.
  always @(posedge clk) begin
    if (mw_en_o) mem[mw_addr_o[9:0]] <= mw_data_o;
    rd_d1 <= mr_en_o ? mem[mr_addr_o[9:0]] : 36'hBAD_F00D_5;
    rd_d2 <= rd_d1;
  end
  assign mr_data_i = rd_d2;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int eff_side(input int lv);
    if (lv == 0) return 1;
    if (lv > 7)  return 8;
    return lv;
  endfunction

  function automatic logic [35:0] pat(input int k);
    return {12'(k + 1), 12'(3 * k + 5), 12'(k ^ 12'h5A5)};
  endfunction

  task automatic t_reset();
    rst_n = 1'b0; level_i = 0; tiles_i = 0; wr_start_i = 0; rd_start_i = 0;
    xf_ready_i = 0; xf_coef_i = 0; wr_base_i = 0; rd_base_i = 0;
    repeat (3) @(negedge clk);
    #4;
    chk(!mw_en_o && !mr_en_o && !co_valid_o, "R10 strobes", {mw_en_o, mr_en_o, co_valid_o}, 0);
    chk(xf_rst_o && !wr_busy_o && !rd_busy_o, "R10 idle", {xf_rst_o, wr_busy_o, rd_busy_o}, 3'b100);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Store frame: gap inserts idle cycles, lvchg alters level mid-frame,
  // restart raises a second start mid-frame.
  task automatic t_store(input int lv, input int tl, input int base,
                         input bit gap, input bit lvchg, input bit restart);
    int n = eff_side(lv);
    int te = (tl == 0) ? 1 : tl;
    int idx = 0, ptr = base, cyc = 0;
    @(negedge clk);
    level_i = 4'(lv); tiles_i = 16'(tl); wr_base_i = 19'(base); wr_start_i = 1;
    #4 chk(xf_rst_o == 1, "R6 reset before frame", xf_rst_o, 1);
    @(negedge clk);
    wr_start_i = 0;
    #1 chk(wr_busy_o && !xf_rst_o, "R6 frame active", {wr_busy_o, xf_rst_o}, 2'b10);
    while (idx < 64 * te) begin
      @(negedge clk);
      xf_ready_i = !(gap && (cyc % 5 == 4));
      xf_coef_i  = pat(idx + base);
      if (lvchg) level_i = (lv == 2) ? 4'd7 : 4'd2;
      wr_start_i = restart && (cyc == 10);
      wr_base_i  = restart ? 19'd900 : 19'(base);
      #4;
      if (xf_ready_i) begin
        int r = (idx % 64) / 8;
        int c = idx % 8;
        bit k = (r < n) && (c < n);
        chk(mw_en_o == k, "R1 R3 R4 keep", mw_en_o, k);
        if (k) begin
          chk(mw_addr_o == 19'(ptr), "R2 R11 packed addr", mw_addr_o, ptr);
          chk(mw_data_o == xf_coef_i, "R1 data", mw_data_o, xf_coef_i);
          ptr++;
        end
        idx++;
      end else begin
        chk(!mw_en_o, "R5 no write without ready", mw_en_o, 0);
      end
      cyc++;
    end
    @(negedge clk);
    wr_start_i = 0; xf_ready_i = 1; xf_coef_i = 36'h123;
    #4;
    chk(!wr_busy_o && xf_rst_o, "R6 frame end", {wr_busy_o, xf_rst_o}, 2'b01);
    chk(!mw_en_o, "R6 write after end", mw_en_o, 0);
    chk(ptr - base == te * n * n, "R2 word count", ptr - base, te * n * n);
    @(negedge clk);
    xf_ready_i = 0; level_i = 0;
  endtask

  task automatic t_load(input int lv, input int tl, input int base,
                        input bit lvchg, input bit restart);
    int n = eff_side(lv);
    int te = (tl == 0) ? 1 : tl;
    int ki = 0, ko = 0;
    for (int j = 0; j < 64; j++) mem[10'(base + j)] = pat(7 * j + base);
    @(negedge clk);
    level_i = 4'(lv); tiles_i = 16'(tl); rd_base_i = 19'(base); rd_start_i = 1;
    @(negedge clk);
    rd_start_i = 0;
    for (int i = 0; i < 64 * te + 2; i++) begin
      if (lvchg) level_i = 4'd1;
      rd_start_i = restart && (i == 20);
      rd_base_i  = restart ? 19'd700 : 19'(base);
      #4;
      if (i < 64 * te) begin
        int r = (i % 64) / 8;
        int c = i % 8;
        bit k = (r < n) && (c < n);
        chk(mr_en_o == k, "R7 R3 R4 read strobe", mr_en_o, k);
        if (k) begin
          chk(mr_addr_o == 19'(base + ki), "R7 R11 read addr", mr_addr_o, base + ki);
          ki++;
        end
      end else begin
        chk(!mr_en_o, "R9 no read after frame", mr_en_o, 0);
      end
      if (i >= 2) begin
        int q = i - 2;
        bit k = ((q % 64) / 8 < n) && (q % 8 < n);
        logic [35:0] e = k ? mem[10'(base + ko)] : 36'h0;
        chk(co_valid_o, "R8 valid", co_valid_o, 1);
        chk(co_data_o == e, "R8 rebuilt word", co_data_o, e);
        if (k) ko++;
      end else begin
        chk(!co_valid_o, "R8 latency", co_valid_o, 0);
      end
      @(negedge clk);
    end
    rd_start_i = 0;
    #4;
    chk(!co_valid_o && !rd_busy_o, "R9 frame end", {co_valid_o, rd_busy_o}, 0);
    @(negedge clk);
    level_i = 0;
  endtask

  bit done = 0;
  initial begin
    #1_500_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_store(3, 2, 40, 0, 0, 0);
    t_store(0, 1, 100, 1, 0, 0);
    t_store(12, 0, 200, 1, 0, 0);
    t_store(5, 1, 300, 0, 1, 1);
    t_load(3, 2, 400, 0, 0);
    t_load(0, 1, 500, 0, 0);
    t_load(9, 1, 600, 0, 0);
    t_load(6, 1, 800, 1, 1);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule